// File: doc/BRIEF.md
# Transfer Stall Watchdog with Single Retry

This block supervises a packet link controller and catches a transfer that has stopped moving. The controller arms a wait counter when it starts waiting on the drive. A periodic tick then advances that counter, and any byte that passes over the link while the controller waits pulls the count back to one. The count therefore measures unbroken idle ticks. When the count passes a limit, the block declares a stall. It pulses commands that re-enable both link directions and force the controller to idle, and it pulses one resolution: a notify when no request is outstanding, a restart of the current request the first time, or a failure of the request if it stalls again.

The block also decides whether it should keep running. It starts when any unit is opened. It stops on a tick that finds every unit closed and no request active; on that tick it also pulses a receive-disable command and clears the wait count. The error count belongs to one request and clears whenever the controller starts a new request.

Top module: `stall_wd`

## Requirements
- R1: After reset, `running` and all pulse outputs (`rx_disable`, `stopped`, `link_reenable`, `force_idle`, `notify`, `restart`, `req_fail`) are low.
- R2: A rising edge on any bit of `unit_open` sets `running` in the next cycle.
- R3: While `running` is high and the block is not idle, a `wait_arm` pulse sets the count to 1, and each `tick` raises a nonzero count by one. The STALL_LIMIT-th tick after the arm is a stall, and no earlier tick is. After a stall the count is zero, so ticks alone never cause another stall.
- R4: A `link_activity` pulse while the count is nonzero resets the count to 1, so the stall falls on the STALL_LIMIT-th tick after that pulse. Activity while the count is zero arms nothing.
- R5: A stall pulses `link_reenable` and `force_idle` high for exactly the one cycle after the stalling tick.
- R6: A stall with `req_active` low pulses `notify`, and does not pulse `restart` or `req_fail`.
- R7: A stall with `req_active` high raises the request's error count by one. If the new count is at most MAX_RETRY, the stall pulses `restart`; otherwise it pulses `req_fail`. At most one of `notify`, `restart` and `req_fail` is high in any cycle.
- R8: A `req_start` pulse resets the error count to zero, so the next stall of that request pulses `restart`.
- R9: When every `unit_open` bit and `req_active` are low, the block is idle. A tick while idle and running pulses `rx_disable` and `stopped` and clears `running`. The count is held at zero while the block is idle, and `wait_arm` has no effect then.
- R10: While `running` is low, ticks do not advance the count, and no stall occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle periodic supervision tick |
| wait_arm | input | 1 | Controller has begun waiting on the drive |
| link_activity | input | 1 | A byte was sent or received by the controller |
| unit_open | input | NUM_UNITS | Per-unit open indication |
| req_active | input | 1 | A request is outstanding |
| req_start | input | 1 | Controller starts a new request |
| running | output | 1 | Supervisor is active and should keep ticking |
| rx_disable | output | 1 | Pulse: disable the receiver on disarm |
| stopped | output | 1 | Pulse: supervisor has stopped |
| link_reenable | output | 1 | Pulse: re-enable receiver and transmitter after a stall |
| force_idle | output | 1 | Pulse: force the controller state to idle |
| notify | output | 1 | Pulse: stall with no request, wake waiters |
| restart | output | 1 | Pulse: re-issue the current request |
| req_fail | output | 1 | Pulse: complete the current request with an error |

## Verification
The bench builds the block with STALL_LIMIT=6, MAX_RETRY=1 and two units. The short limit lets it test every position of an activity pulse inside the wait window, each tick of the window up to the stall, and the tick where the stall lands. With a retry budget of one, the bench can also run a restart, a failure and a further failure of one request, and then check that a new request returns to a restart. The bench also covers disarm and re-arm through the unit opens, including a count left armed across the idle period.

// File: rtl/stall_wd_pkg.sv
// Shared types for the transfer stall watchdog.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package stall_wd_pkg;

    // Outcome chosen for one detected stall.
    typedef enum logic [1:0] {
        RES_NONE   = 2'd0,
        RES_NOTIFY = 2'd1,
        RES_RETRY  = 2'd2,
        RES_FAIL   = 2'd3
    } stall_res_t;

    // Width large enough to hold values 0..max_val.
    function automatic int width_for(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/stall_wd_arming.sv
// Run/stop control of the watchdog.
// Detects unit open edges (which start the supervisor) and the idle
// condition (all units closed, no request), which stops it on a tick.
// Assumes: unit_open and req_active are synchronous to clk.
module stall_wd_arming #(
    parameter int NUM_UNITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [NUM_UNITS-1:0] unit_open,
    input  logic                 req_active,
    output logic                 running,
    output logic                 idle,
    output logic                 rx_disable,
    output logic                 stopped
);

    logic [NUM_UNITS-1:0] open_q;
    logic [NUM_UNITS-1:0] open_rise;
    logic                 any_rise;
    logic                 stop_now;

    // Per-unit edge detector on the open indication.
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        // Remember last open level of this unit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[u] <= 1'b0;
            end else begin
                open_q[u] <= unit_open[u];
            end
        end
        assign open_rise[u] = unit_open[u] & ~open_q[u];
    end

    // Idle and stop conditions.
    always_comb begin
        any_rise = |open_rise;
        idle     = ~(|unit_open) & ~req_active;
        stop_now = tick & running & idle;
    end

    // Running flag plus stop pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running    <= 1'b0;
            rx_disable <= 1'b0;
            stopped    <= 1'b0;
        end else begin
            rx_disable <= stop_now;
            stopped    <= stop_now;
            if (any_rise) begin
                running <= 1'b1;
            end else if (stop_now) begin
                running <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/stall_wd_counter.sv
// Idle-tick wait counter and stall detector.
// Zero means not waiting. An arm sets it to 1, link activity while
// waiting sets it back to 1, and each tick while running raises it.
// A tick that would carry it past STALL_LIMIT is a stall (combinational
// strobe), and the count returns to zero.
// Assumes: tick is a single-cycle strobe.
module stall_wd_counter #(
    parameter int STALL_LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic running,
    input  logic idle,
    input  logic wait_arm,
    input  logic link_activity,
    output logic stall
);

    localparam int CW = stall_wd_pkg::width_for(STALL_LIMIT);
    localparam logic [CW-1:0] LIMIT_V = CW'(STALL_LIMIT);
    localparam logic [CW-1:0] ONE_V   = CW'(1);

    logic [CW-1:0] cnt;
    logic          waiting;
    logic          counting;

    // Stall detect: this tick would take the count past the limit.
    always_comb begin
        waiting  = (cnt != '0);
        counting = tick & running & ~idle & waiting;
        stall    = counting & (cnt >= LIMIT_V);
    end

    // Counter update with disarm, stall, arm and tick priorities.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (idle) begin
            cnt <= '0;
        end else if (stall) begin
            cnt <= '0;
        end else if (wait_arm || (link_activity && waiting)) begin
            cnt <= ONE_V;
        end else if (counting) begin
            cnt <= cnt + ONE_V;
        end
    end

endmodule

// File: rtl/stall_wd_resolver.sv
// Stall resolution: keeps a per-request error count and picks notify,
// restart or fail, and drives the registered recovery pulses.
// Assumes: req_start marks the beginning of each new request.
module stall_wd_resolver #(
    parameter int MAX_RETRY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic req_active,
    input  logic req_start,
    output logic link_reenable,
    output logic force_idle,
    output logic notify,
    output logic restart,
    output logic req_fail
);
    import stall_wd_pkg::*;

    localparam int EW = width_for(MAX_RETRY + 1);
    localparam logic [EW-1:0] SAT_V   = EW'(MAX_RETRY + 1);
    localparam logic [EW-1:0] RETRY_V = EW'(MAX_RETRY);

    logic [EW-1:0] err_cnt;
    logic [EW-1:0] err_next;
    stall_res_t    res;

    // Choose the outcome of a stall from the bumped error count.
    always_comb begin
        err_next = (err_cnt == SAT_V) ? err_cnt : err_cnt + EW'(1);
        res      = RES_NONE;
        if (stall) begin
            if (!req_active) begin
                res = RES_NOTIFY;
            end else if (err_next <= RETRY_V) begin
                res = RES_RETRY;
            end else begin
                res = RES_FAIL;
            end
        end
    end

    // Per-request error count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_cnt <= '0;
        end else if (req_start) begin
            err_cnt <= '0;
        end else if (stall && req_active) begin
            err_cnt <= err_next;
        end
    end

    // Registered one-cycle recovery pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_reenable <= 1'b0;
            force_idle    <= 1'b0;
            notify        <= 1'b0;
            restart       <= 1'b0;
            req_fail      <= 1'b0;
        end else begin
            link_reenable <= stall;
            force_idle    <= stall;
            notify        <= (res == RES_NOTIFY);
            restart       <= (res == RES_RETRY);
            req_fail      <= (res == RES_FAIL);
        end
    end

endmodule

// File: rtl/stall_wd.sv
// Transfer stall watchdog top.
// Joins run/stop control, the idle-tick counter and the stall resolver.
// Assumes: all inputs synchronous to clk; tick, wait_arm,
// link_activity and req_start are single-cycle strobes.
module stall_wd #(
    parameter int NUM_UNITS   = 2,
    parameter int STALL_LIMIT = 40,
    parameter int MAX_RETRY   = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 wait_arm,
    input  logic                 link_activity,
    input  logic [NUM_UNITS-1:0] unit_open,
    input  logic                 req_active,
    input  logic                 req_start,
    output logic                 running,
    output logic                 rx_disable,
    output logic                 stopped,
    output logic                 link_reenable,
    output logic                 force_idle,
    output logic                 notify,
    output logic                 restart,
    output logic                 req_fail
);

    logic idle;
    logic stall;

    // Run/stop control.
    stall_wd_arming #(.NUM_UNITS(NUM_UNITS)) u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .unit_open  (unit_open),
        .req_active (req_active),
        .running    (running),
        .idle       (idle),
        .rx_disable (rx_disable),
        .stopped    (stopped)
    );

    // Idle-tick counting and stall strobe.
    stall_wd_counter #(.STALL_LIMIT(STALL_LIMIT)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .running       (running),
        .idle          (idle),
        .wait_arm      (wait_arm),
        .link_activity (link_activity),
        .stall         (stall)
    );

    // Outcome selection and recovery pulses.
    stall_wd_resolver #(.MAX_RETRY(MAX_RETRY)) u_res (
        .clk           (clk),
        .rst_n         (rst_n),
        .stall         (stall),
        .req_active    (req_active),
        .req_start     (req_start),
        .link_reenable (link_reenable),
        .force_idle    (force_idle),
        .notify        (notify),
        .restart       (restart),
        .req_fail      (req_fail)
    );

endmodule

// File: rtl/stall_wd_checker.sv
// Port-level protocol checks for stall_wd, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module stall_wd_checker #(
    parameter int NUM_UNITS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic [NUM_UNITS-1:0] unit_open,
    input logic                 req_active,
    input logic                 running,
    input logic                 rx_disable,
    input logic                 stopped,
    input logic                 link_reenable,
    input logic                 force_idle,
    input logic                 notify,
    input logic                 restart,
    input logic                 req_fail
);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({notify, restart, req_fail})); // R7

    AST_OUTCOME_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (notify || restart || req_fail) |-> (force_idle && link_reenable)); // R5

    AST_STALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        force_idle |-> $past(tick)); // R3

    AST_NOTIFY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> !$past(req_active)); // R6

    AST_RETRY_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (restart || req_fail) |-> $past(req_active)); // R7

    AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> (!running && rx_disable)); // R9

    AST_STOP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> (!$past(req_active) && !(|$past(unit_open)))); // R9

    AST_NO_STALL_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        force_idle |-> $past(running)); // R10

endmodule

bind stall_wd stall_wd_checker #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .unit_open     (unit_open),
    .req_active    (req_active),
    .running       (running),
    .rx_disable    (rx_disable),
    .stopped       (stopped),
    .link_reenable (link_reenable),
    .force_idle    (force_idle),
    .notify        (notify),
    .restart       (restart),
    .req_fail      (req_fail)
);

// File: tb/stall_wd_test.sv
// Self-checking bench for stall_wd with a short stall window.
module stall_wd_test;

    localparam int LIM   = 6;
    localparam int RETRY = 1;
    localparam int NU    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wait_arm = 1'b0;
    logic          link_activity = 1'b0;
    logic [NU-1:0] unit_open = '0;
    logic          req_active = 1'b0;
    logic          req_start = 1'b0;
    logic running, rx_disable, stopped, link_reenable, force_idle;
    logic notify, restart, req_fail;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Captured outputs of the last tick.
    int r_res;
    int r_force;
    int r_reen;
    int r_stop;
    int r_rxd;

    stall_wd #(.NUM_UNITS(NU), .STALL_LIMIT(LIM), .MAX_RETRY(RETRY)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wait_arm(wait_arm),
        .link_activity(link_activity), .unit_open(unit_open),
        .req_active(req_active), .req_start(req_start),
        .running(running), .rx_disable(rx_disable), .stopped(stopped),
        .link_reenable(link_reenable), .force_idle(force_idle),
        .notify(notify), .restart(restart), .req_fail(req_fail)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One tick strobe; captures the outputs the tick produced.
    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        r_force = int'(force_idle);
        r_reen  = int'(link_reenable);
        r_stop  = int'(stopped);
        r_rxd   = int'(rx_disable);
        r_res   = int'(notify) + 2 * int'(restart) + 3 * int'(req_fail);
    endtask

    task automatic pulse_arm();
        @(negedge clk) wait_arm = 1'b1;
        @(negedge clk) wait_arm = 1'b0;
    endtask

    task automatic pulse_act();
        @(negedge clk) link_activity = 1'b1;
        @(negedge clk) link_activity = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) req_start = 1'b1;
        @(negedge clk) req_start = 1'b0;
    endtask

    // Run a full window after an arm/activity; expect the stall at LIM.
    task automatic window(input string req, input int exp_res);
        for (int i = 1; i <= LIM; i++) begin
            do_tick();
            chk(req, r_force, (i == LIM) ? 1 : 0);
            if (i == LIM) begin
                chk(req, r_res, exp_res);
                chk("R5", r_reen, 1);
            end
        end
        @(negedge clk);
        chk("R5", int'(force_idle), 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog on the whole run.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", int'({running, rx_disable, stopped, link_reenable,
                        force_idle, notify, restart, req_fail}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(running), 0);

        // R10: not running, not idle: ticks never stall
        req_active = 1'b1;
        pulse_arm();
        for (int i = 0; i < 2 * LIM; i++) begin
            do_tick();
            chk("R10", r_force, 0);
        end
        chk("R10", int'(running), 0);

        // R2: opening a unit starts the supervisor
        @(negedge clk) unit_open[0] = 1'b1;
        @(negedge clk);
        chk("R2", int'(running), 1);
        req_active = 1'b0;

        // R3 R6: stall with no request on the LIM-th tick, notify outcome
        pulse_arm();
        window("R3", 1);
        for (int i = 0; i < 3 * LIM; i++) begin
            do_tick();
            chk("R3", r_force, 0);
        end

        // R4: activity at every position of the window restarts it
        for (int k = 1; k < LIM; k++) begin
            pulse_arm();
            for (int i = 0; i < k; i++) begin
                do_tick();
                chk("R4", r_force, 0);
            end
            pulse_act();
            window("R4", 1);
        end
        pulse_act();
        for (int i = 0; i < 2 * LIM; i++) begin
            do_tick();
            chk("R4", r_force, 0);
        end

        // R7: first stall restarts, later ones fail
        req_active = 1'b1;
        pulse_start();
        for (int n = 1; n <= 3; n++) begin
            pulse_arm();
            window("R7", (n <= RETRY) ? 2 : 3);
        end

        // R8: new request resets the error count
        pulse_start();
        pulse_arm();
        window("R8", 2);
        pulse_arm();
        window("R8", 3);

        // R9: disarm on idle tick, clears count, later reopen
        req_active = 1'b0;
        pulse_arm();
        @(negedge clk) unit_open = '0;
        pulse_arm();
        do_tick();
        chk("R9", r_stop, 1);
        chk("R9", r_rxd, 1);
        chk("R9", int'(running), 0);
        do_tick();
        chk("R9", r_stop, 0);
        chk("R9", int'(running), 0);
        @(negedge clk) unit_open[1] = 1'b1;
        @(negedge clk);
        chk("R2", int'(running), 1);
        for (int i = 0; i < 2 * LIM; i++) begin
            do_tick();
            chk("R9", r_force, 0);
        end
        pulse_arm();
        window("R9", 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule